// File: doc/BRIEF.md
# SPI Mode-Fault Protection Controller

This block is the control and status logic that guards an SPI port against two masters driving the same bus. Software programs a control register with three single-bit functions: port enable, master select and fault-detect enable. While the port is enabled as a master and detection is on, the block watches the slave-select input through a synchronizer. If that input is pulled low by another master, the block records a sticky mode fault, raises an interrupt and drops the port into disabled slave mode in the same update.

The port stays locked in that state until software clears the fault flag by writing 1 to it. While the flag is set, hardware refuses any write that tries to set the enable or master bits. All other control bits still update. A flag register shows the live, synchronized slave-select level, so software can confirm the bus is free before it enables master mode again.

The block also drives the output-enables of the MOSI, MISO and SPI clock pads. It also selects whether the slave-select output pins follow the SPI engine or a general-purpose flag module's value and direction bits.

Top module: `spi_fault_guard`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), the control and status registers read 0, `irq` is 0, all pad output-enables are 0, and the slave-select pins carry `gpf_out`/`gpf_oe`. The synchronizer resets to the idle-high level.
- R2: Register map: address 0 is control, with bit 0 enable, bit 1 master, bit 2 detect-enable and bits 7:3 general. Address 1 is status, with bit 0 the mode fault. Address 2 is the flag register. When enable, master and detect-enable are all 1 and the synchronized slave-select level is 0, the next clock edge clears enable and master and sets the fault bit.
- R3: While detect-enable (control bit 2) is 0, a low slave-select input never sets the fault bit.
- R4: A write of 1 to status bit 0 clears the fault bit. A write of 0 to status bit 0 leaves it set.
- R5: While the fault bit is set, a control write cannot set enable (bit 0) or master (bit 1). Bits 7:2 of the same write still take the written value.
- R6: `irq` equals the fault bit. It rises in the cycle the fault is recorded and falls in the cycle after the clearing write.
- R7: Flag register bit 7 shows the slave-select input level after a two-flop synchronizer, so a change becomes visible two clock edges after it is applied. The other flag bits read 0.
- R8: If enable and master are written to 1 while detection is on and the synchronized slave-select is still low, a new fault is recorded on the very next clock edge.
- R9: `mosi_oe` and `sck_oe` are 1 only when enable and master are both 1. `miso_oe` is 1 only when enable is 1 and master is 0. All three are 0 when enable is 0.
- R10: When enable and master are both 1, `ss_out` follows `spi_ss_out` and every `ss_oe` bit is 1. Otherwise `ss_out` follows `gpf_out` and `ss_oe` follows `gpf_oe`.
- R11: If a fault is detected at the same clock edge as a control write, the fault wins for enable and master (both cleared, fault set). The other control bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ss_in | input | 1 | Asynchronous slave-select input, active low |
| spi_ss_out | input | NUM_SS | Slave-select values from the SPI engine |
| gpf_out | input | NUM_SS | Slave-select values from the flag module |
| gpf_oe | input | NUM_SS | Slave-select directions from the flag module |
| ss_out | output | NUM_SS | Slave-select pin values |
| ss_oe | output | NUM_SS | Slave-select pin output-enables |
| mosi_oe | output | 1 | MOSI pad output-enable |
| miso_oe | output | 1 | MISO pad output-enable |
| sck_oe | output | 1 | SPI clock pad output-enable |
| irq | output | 1 | Mode-fault interrupt |

## Verification
Fault detection and a software write to the control register can land on the same clock edge. In that case the fault must override enable and master, while the write still sets the remaining control bits. The bench provokes this by pulling the slave-select input low and counting the two synchronizer edges. It then issues a control write that keeps enable and master at 1 and sets a distinctive general-bit pattern, timed so that the write and the detection meet at one edge. The result is judged by reading back control, status and `irq`. The expected values are enable and master at 0, detect-enable and the new general bits as written, and the fault bit set.

// File: rtl/spi_fg_pkg.sv
package spi_fg_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STS = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLG = 2'd2;

  localparam int STS_FAULT_BIT = 0;
  localparam int FLG_SS_BIT    = 7;

  typedef struct packed {
    logic [4:0] spare;
    logic       det;
    logic       master;
    logic       en;
  } ctl_t;

  typedef struct packed {
    logic mosi;
    logic miso;
    logic sck;
  } pad_oe_t;

  // Contention condition: active master with detection armed sees select low.
  function automatic logic mode_fault(ctl_t c, logic ss_lvl);
    return c.en & c.master & c.det & ~ss_lvl;
  endfunction

  // Next control value: write with lock on enable/master, then fault override.
  function automatic ctl_t next_ctl(ctl_t cur, logic [REG_W-1:0] wd,
                                    logic wr, logic locked, logic flt);
    ctl_t n;
    n = cur;
    if (wr) begin
      n = ctl_t'(wd);
      if (locked) begin
        n.en     = cur.en;
        n.master = cur.master;
      end
    end
    if (flt) begin
      n.en     = 1'b0;
      n.master = 1'b0;
    end
    return n;
  endfunction

  function automatic pad_oe_t pad_oe(ctl_t c);
    pad_oe_t p;
    p.mosi = c.en & c.master;
    p.sck  = c.en & c.master;
    p.miso = c.en & ~c.master;
    return p;
  endfunction

  function automatic logic spi_owns_ss(ctl_t c);
    return c.en & c.master;
  endfunction
endpackage

// File: rtl/spi_fg_sync.sv
module spi_fg_sync #(
  parameter int   STAGES    = 2,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_LEVEL}};
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_fg_regs.sv
module spi_fg_regs
  import spi_fg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              ss_sync,
  output ctl_t              ctl_q,
  output logic              fault_q,
  output logic              fault_evt
);
  logic ctl_wr, sts_wr, fault_clr;
  ctl_t ctl_n;
  logic fault_n;

  assign ctl_wr    = wr_en && (wr_addr == A_CTL);
  assign sts_wr    = wr_en && (wr_addr == A_STS);
  assign fault_clr = sts_wr && wr_data[STS_FAULT_BIT];
  assign fault_evt = mode_fault(ctl_q, ss_sync);

  always_comb begin
    ctl_n = next_ctl(ctl_q, wr_data, ctl_wr, fault_q, fault_evt);
    if (fault_evt)      fault_n = 1'b1;
    else if (fault_clr) fault_n = 1'b0;
    else                fault_n = fault_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_n;
      fault_q <= fault_n;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTL:   rd_data = ctl_q;
      A_STS:   rd_data[STS_FAULT_BIT] = fault_q;
      A_FLG:   rd_data[FLG_SS_BIT] = ss_sync;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/spi_fg_padmux.sv
module spi_fg_padmux
  import spi_fg_pkg::*;
#(
  parameter int NUM_SS = 4
) (
  input  ctl_t              ctl,
  input  logic [NUM_SS-1:0] spi_ss_out,
  input  logic [NUM_SS-1:0] gpf_out,
  input  logic [NUM_SS-1:0] gpf_oe,
  output logic [NUM_SS-1:0] ss_out,
  output logic [NUM_SS-1:0] ss_oe,
  output logic              mosi_oe,
  output logic              miso_oe,
  output logic              sck_oe
);
  pad_oe_t p;
  logic    own;

  assign p       = pad_oe(ctl);
  assign own     = spi_owns_ss(ctl);
  assign mosi_oe = p.mosi;
  assign miso_oe = p.miso;
  assign sck_oe  = p.sck;

  for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
    assign ss_out[i] = own ? spi_ss_out[i] : gpf_out[i];
    assign ss_oe[i]  = own ? 1'b1          : gpf_oe[i];
  end
endmodule

// File: rtl/spi_fault_guard.sv
module spi_fault_guard
  import spi_fg_pkg::*;
#(
  parameter int NUM_SS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              ss_in,
  input  logic [NUM_SS-1:0] spi_ss_out,
  input  logic [NUM_SS-1:0] gpf_out,
  input  logic [NUM_SS-1:0] gpf_oe,
  output logic [NUM_SS-1:0] ss_out,
  output logic [NUM_SS-1:0] ss_oe,
  output logic              mosi_oe,
  output logic              miso_oe,
  output logic              sck_oe,
  output logic              irq
);
  logic ss_sync;
  ctl_t ctl_q;
  logic sts_fault;
  logic fault_evt;
  logic ctl_en, ctl_master, ctl_det;

  spi_fg_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_async(ss_in), .q_sync(ss_sync)
  );

  spi_fg_regs u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ss_sync(ss_sync), .ctl_q(ctl_q),
    .fault_q(sts_fault), .fault_evt(fault_evt)
  );

  spi_fg_padmux #(.NUM_SS(NUM_SS)) u_pad (
    .ctl(ctl_q), .spi_ss_out(spi_ss_out),
    .gpf_out(gpf_out), .gpf_oe(gpf_oe),
    .ss_out(ss_out), .ss_oe(ss_oe),
    .mosi_oe(mosi_oe), .miso_oe(miso_oe), .sck_oe(sck_oe)
  );

  assign ctl_en     = ctl_q.en;
  assign ctl_master = ctl_q.master;
  assign ctl_det    = ctl_q.det;
  assign irq        = sts_fault;
endmodule

// File: rtl/spi_fg_chk.sv
module spi_fg_chk
  import spi_fg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              fault_evt,
  input logic              ctl_en,
  input logic              ctl_master,
  input logic              ctl_det,
  input logic              sts_fault,
  input logic              irq,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [REG_W-1:0]  wr_data,
  input logic              mosi_oe,
  input logic              miso_oe,
  input logic              sck_oe
);
  logic sts_wr, ctl_wr;
  assign sts_wr = wr_en && (wr_addr == A_STS);
  assign ctl_wr = wr_en && (wr_addr == A_CTL);

  p_fault_disables_r2: assert property (@(posedge clk) disable iff (rst)
    fault_evt |=> (!ctl_en && !ctl_master && sts_fault));

  p_no_detect_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctl_det && !sts_fault) |=> !sts_fault);

  p_w1c_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (sts_fault && sts_wr && wr_data[STS_FAULT_BIT]) |=> !sts_fault);

  p_w0_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (sts_fault && sts_wr && !wr_data[STS_FAULT_BIT]) |=> sts_fault);

  p_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (sts_fault && ctl_wr) |=> (!ctl_en && !ctl_master));

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(fault_evt));

  p_irq_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(sts_fault) |-> !irq);

  p_pads_off_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |-> (!mosi_oe && !miso_oe && !sck_oe));
endmodule

bind spi_fault_guard spi_fg_chk u_chk (
  .clk(clk), .rst(rst), .fault_evt(fault_evt),
  .ctl_en(ctl_en), .ctl_master(ctl_master), .ctl_det(ctl_det),
  .sts_fault(sts_fault), .irq(irq),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe), .sck_oe(sck_oe)
);

// File: tb/tb_spi_fault_guard.sv
`timescale 1ns/1ps
module tb_spi_fault_guard;
  localparam int NSS = 4;

  logic           clk = 1'b0;
  logic           rst;
  logic           wr_en;
  logic [1:0]     wr_addr;
  logic [7:0]     wr_data;
  logic [1:0]     rd_addr;
  logic [7:0]     rd_data;
  logic           ss_in;
  logic [NSS-1:0] spi_ss_out, gpf_out, gpf_oe, ss_out, ss_oe;
  logic           mosi_oe, miso_oe, sck_oe, irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spi_fault_guard #(.NUM_SS(NSS), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ss_in(ss_in),
    .spi_ss_out(spi_ss_out), .gpf_out(gpf_out), .gpf_oe(gpf_oe),
    .ss_out(ss_out), .ss_oe(ss_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
    .sck_oe(sck_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
  endtask

  // Bring port to enabled master with detection and clear any fault.
  task automatic arm_master();
    ss_in = 1'b1; step(); step(); step();
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h07);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    rd(2'd0, v); check("R1 ctl", v, 8'h00);
    rd(2'd1, v); check("R1 sts", v, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 oe", {mosi_oe, miso_oe, sck_oe}, 3'b000);
    check("R1 ss_out", ss_out, gpf_out);
    check("R1 ss_oe", ss_oe, gpf_oe);
    rd(2'd2, v); check("R1 flag idle high", v, 8'h80);
  endtask

  task automatic t_flag();
    logic [7:0] v;
    ss_in = 1'b0; step();
    rd(2'd2, v); check("R7 flag after 1 edge", v, 8'h80);
    step();
    rd(2'd2, v); check("R7 flag after 2 edges", v, 8'h00);
    ss_in = 1'b1; step(); step();
    rd(2'd2, v); check("R7 flag back high", v, 8'h80);
  endtask

  task automatic t_pads();
    wr(2'd0, 8'h01);
    check("R9 slave oe", {mosi_oe, miso_oe, sck_oe}, 3'b010);
    check("R10 slave ss_out", ss_out, gpf_out);
    check("R10 slave ss_oe", ss_oe, gpf_oe);
    wr(2'd0, 8'h03);
    check("R9 master oe", {mosi_oe, miso_oe, sck_oe}, 3'b101);
    check("R10 master ss_out", ss_out, spi_ss_out);
    check("R10 master ss_oe", ss_oe, 4'hF);
    wr(2'd0, 8'h02);
    check("R9 disabled oe", {mosi_oe, miso_oe, sck_oe}, 3'b000);
  endtask

  task automatic t_no_detect();
    logic [7:0] v;
    ss_in = 1'b1; step(); step();
    wr(2'd0, 8'h03);
    ss_in = 1'b0; repeat (5) step();
    rd(2'd1, v); check("R3 no fault w/o detect", v, 8'h00);
    rd(2'd0, v); check("R3 ctl kept", v, 8'h03);
    ss_in = 1'b1; step(); step();
  endtask

  task automatic t_fault_basic();
    logic [7:0] v;
    arm_master();
    check("R6 irq low while armed", irq, 0);
    ss_in = 1'b0; step(); step();
    check("R2 no fault before edge", irq, 0);
    step();
    rd(2'd1, v); check("R2 fault set", v, 8'h01);
    rd(2'd0, v); check("R2 en/master cleared", v, 8'h04);
    check("R6 irq with fault", irq, 1);
    check("R9 oe off after fault", {mosi_oe, miso_oe, sck_oe}, 3'b000);
    check("R10 ss back to flag module", ss_out, gpf_out);
    check("R10 ss_oe back to flag module", ss_oe, gpf_oe);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    wr(2'd1, 8'hFE);
    rd(2'd1, v); check("R4 write 0 keeps", v, 8'h01);
    check("R6 irq kept", irq, 1);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R4 write 1 clears", v, 8'h00);
    check("R6 irq cleared", irq, 0);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    // fault is set on entry
    wr(2'd0, 8'hFB);
    rd(2'd0, v); check("R5 en/master locked, others update", v, 8'hF8);
    check("R5 pads stay off", {mosi_oe, miso_oe, sck_oe}, 3'b000);
  endtask

  task automatic t_reenable_low();
    logic [7:0] v;
    // ss_in still low and synced; fault set
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h07);
    rd(2'd0, v); check("R8 enabled for one cycle", v, 8'h07);
    step();
    rd(2'd1, v); check("R8 immediate new fault", v, 8'h01);
    rd(2'd0, v); check("R8 ctl forced off", v, 8'h04);
    check("R8 irq", irq, 1);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    arm_master();
    ss_in = 1'b0; step(); step();
    wr(2'd0, 8'hAF);
    rd(2'd0, v); check("R11 fault wins, other bits written", v, 8'hAC);
    rd(2'd1, v); check("R11 fault set", v, 8'h01);
    check("R11 irq", irq, 1);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    ss_in = 1'b1;
    spi_ss_out = 4'b0110; gpf_out = 4'b1001; gpf_oe = 4'b0011;
    t_reset();
    t_flag();
    t_pads();
    t_no_detect();
    t_fault_basic();
    t_w1c();
    wr(2'd0, 8'h07);
    step();
    t_lock();
    t_reenable_low();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule